// File: doc/BRIEF.md
# Interrupt Status and Enable Controller

This block collects eight event lines from a serial bus controller and turns them into one interrupt request. Each event line is edge-detected: a low-to-high transition latches a sticky pending bit in a status register. Software chooses which pending bits may raise the request through an 8-bit enable mask, and a single global enable bit gates the whole output. Pending bits stay set until software writes ones to their positions in the status register.

A keyed soft-reset register lets software return the controller to its default state. Writing the key clears every register in this block and raises a one-cycle reset strobe for the rest of the controller. Registers are reached through a simple read/write port that takes word indices. Read data comes back one cycle after the read request.

Top module: `irqAggregator`

## Requirements
- R1: After hard reset the status, enable and global-enable registers read as zero, and both `irqOut` and `softRstOut` are low.
- R2: A status bit becomes 1 on the clock edge where its event input is first seen high after being low. It then holds that value until it is cleared. An event input that stays high does not set the bit again.
- R3: Status bit k follows `evtIn[k]`. The positions are fixed: 0 arbitration lost, 1 transmit error or completion, 2 transmit empty, 3 receive watermark, 4 bus idle, 5 addressed as target, 6 no longer addressed, 7 transmit half empty.
- R4: A write to the status register (word index 8) clears each bit whose data bit [k] is 1. Bits written with 0 keep their value.
- R5: If a rising edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: `irqOut` is high exactly when the global enable is 1 and at least one bit is 1 in both the status and enable registers.
- R7: The global-enable register (word index 7) stores only data bit 31. All its other bits read as 0.
- R8: The enable register (word index 10) stores data bits [7:0] and reads them back in the same positions, with the upper bits as 0.
- R9: Writing exactly 0x0000000A to the reset register (word index 16) clears status, enable and global enable on that edge. It also drives `softRstOut` high for exactly one cycle.
- R10: Writing any other value to the reset register changes no register and leaves `softRstOut` low.
- R11: Reads return data on `regRdata` with `regRvalid` high one cycle after `regRd`. The reset register and unmapped indices read as 0, and writes to unmapped indices have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous hard reset |
| evtIn | input | 8 | Event source levels, one per status bit |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 5 | Word index of the accessed register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid with regRvalid |
| regRvalid | output | 1 | Read data valid, one cycle after regRd |
| irqOut | output | 1 | Combined interrupt request |
| softRstOut | output | 1 | One-cycle controller reset strobe |

## Verification
The properties assume that the event inputs are low while hard reset is applied. With that, the first edge seen after reset is a true rising edge. They also assume that reads and writes are single-cycle strobes that never overlap. The stimulus meets both assumptions: it holds `evtIn` at zero through reset, changes the event lines and the register port only on falling clock edges, and issues one access per cycle. The set-versus-clear collision is driven on purpose, with the event edge and the clearing write in the same cycle.

// File: rtl/irqAggregatorPkg.sv
package irqAggregatorPkg;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_GLB  = 2'd1,
    RD_STS  = 2'd2,
    RD_ENA  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrGlb;
    logic   wrSts;
    logic   wrEna;
    logic   softRst;
    logic   rdReq;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/irqAggregatorDecode.sv
module irqAggregatorDecode
  import irqAggregatorPkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int GLB_IDX = 7,
  parameter int STS_IDX = 8,
  parameter int ENA_IDX = 10,
  parameter int RST_IDX = 16,
  parameter logic [DATA_W-1:0] RST_KEY = 'hA
) (
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output regStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] GLB_A = ADDR_W'(GLB_IDX);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_IDX);
  localparam logic [ADDR_W-1:0] ENA_A = ADDR_W'(ENA_IDX);
  localparam logic [ADDR_W-1:0] RST_A = ADDR_W'(RST_IDX);

  logic hitGlb, hitSts, hitEna, hitRst, keyOk;

  always_comb begin
    hitGlb = (regAddr == GLB_A);
    hitSts = (regAddr == STS_A);
    hitEna = (regAddr == ENA_A);
    hitRst = (regAddr == RST_A);
    keyOk  = (regWdata == RST_KEY);

    strobe.wrGlb   = regWr & hitGlb;
    strobe.wrSts   = regWr & hitSts;
    strobe.wrEna   = regWr & hitEna;
    strobe.softRst = regWr & hitRst & keyOk;
    strobe.rdReq   = regRd;

    if (hitGlb)      strobe.rdSel = RD_GLB;
    else if (hitSts) strobe.rdSel = RD_STS;
    else if (hitEna) strobe.rdSel = RD_ENA;
    else             strobe.rdSel = RD_ZERO;
  end

endmodule

// File: rtl/irqAggregatorRegs.sv
module irqAggregatorRegs
  import irqAggregatorPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 32,
  parameter int GLB_BIT = 31
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobe,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [NUM_SRC-1:0] evtIn,
  output logic [NUM_SRC-1:0] stsQ,
  output logic [NUM_SRC-1:0] enaQ,
  output logic               glbQ,
  output logic [DATA_W-1:0]  regRdata,
  output logic               regRvalid,
  output logic               irqOut,
  output logic               softRstOut
);

  logic [NUM_SRC-1:0] evtPrev;
  logic [NUM_SRC-1:0] evtRise;
  logic [DATA_W-1:0]  rdNext;

  // Edge history follows the hard reset only, so a line held high across
  // a soft reset does not raise a fresh pending bit.
  always_ff @(posedge clk) begin
    if (!rstN) evtPrev <= '0;
    else       evtPrev <= evtIn;
  end

  assign evtRise = evtIn & ~evtPrev;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_sts
    always_ff @(posedge clk) begin
      if (!rstN)                              stsQ[k] <= 1'b0;
      else if (strobe.softRst)                stsQ[k] <= 1'b0;
      else if (evtRise[k])                    stsQ[k] <= 1'b1;
      else if (strobe.wrSts && regWdata[k])   stsQ[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.softRst) begin
      enaQ <= '0;
      glbQ <= 1'b0;
    end else begin
      if (strobe.wrEna) enaQ <= regWdata[NUM_SRC-1:0];
      if (strobe.wrGlb) glbQ <= regWdata[GLB_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) softRstOut <= 1'b0;
    else       softRstOut <= strobe.softRst;
  end

  always_comb begin
    rdNext = '0;
    unique case (strobe.rdSel)
      RD_GLB:  rdNext[GLB_BIT]        = glbQ;
      RD_STS:  rdNext[NUM_SRC-1:0]    = stsQ;
      RD_ENA:  rdNext[NUM_SRC-1:0]    = enaQ;
      default: rdNext                 = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRvalid <= 1'b0;
      regRdata  <= '0;
    end else begin
      regRvalid <= strobe.rdReq;
      if (strobe.rdReq) regRdata <= rdNext;
    end
  end

  assign irqOut = glbQ & (|(stsQ & enaQ));

endmodule

// File: rtl/irqAggregator.sv
module irqAggregator
  import irqAggregatorPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int GLB_BIT = 31,
  parameter int GLB_IDX = 7,
  parameter int STS_IDX = 8,
  parameter int ENA_IDX = 10,
  parameter int RST_IDX = 16,
  parameter logic [DATA_W-1:0] RST_KEY = 'hA
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               regRvalid,
  output logic               irqOut,
  output logic               softRstOut
);

  regStrobe_t         strobe;
  logic [NUM_SRC-1:0] stsQ;
  logic [NUM_SRC-1:0] enaQ;
  logic               glbQ;

  irqAggregatorDecode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLB_IDX(GLB_IDX), .STS_IDX(STS_IDX),
    .ENA_IDX(ENA_IDX), .RST_IDX(RST_IDX), .RST_KEY(RST_KEY)
  ) uDecode (
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
    .strobe(strobe)
  );

  irqAggregatorRegs #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .GLB_BIT(GLB_BIT)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWdata(regWdata),
    .evtIn(evtIn), .stsQ(stsQ), .enaQ(enaQ), .glbQ(glbQ),
    .regRdata(regRdata), .regRvalid(regRvalid), .irqOut(irqOut),
    .softRstOut(softRstOut)
  );

endmodule

// File: rtl/irqAggregatorChk.sv
module irqAggregatorChk #(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int STS_IDX = 8,
  parameter int RST_IDX = 16,
  parameter logic [DATA_W-1:0] RST_KEY = 'hA
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] evtIn,
  input logic               regWr,
  input logic               regRd,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWdata,
  input logic               regRvalid,
  input logic               irqOut,
  input logic               softRstOut,
  input logic [NUM_SRC-1:0] stsQ,
  input logic [NUM_SRC-1:0] enaQ,
  input logic               glbQ
);

  logic [NUM_SRC-1:0] seenEvt;
  logic [NUM_SRC-1:0] riseNow;
  logic               keyWr, stsWr, rstAddrWr;

  always_ff @(posedge clk) begin
    if (!rstN) seenEvt <= '0;
    else       seenEvt <= evtIn;
  end

  assign riseNow   = evtIn & ~seenEvt;
  assign rstAddrWr = regWr && (regAddr == ADDR_W'(RST_IDX));
  assign keyWr     = rstAddrWr && (regWdata == RST_KEY);
  assign stsWr     = regWr && (regAddr == ADDR_W'(STS_IDX));

  AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    ((riseNow != '0) && !keyWr) |=> ((stsQ & $past(riseNow)) == $past(riseNow))); // R5

  AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!regWr && (riseNow == '0)) |=> $stable(stsQ)); // R2

  AST_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (stsWr && (riseNow == '0)) |=> ((stsQ & $past(regWdata[NUM_SRC-1:0])) == '0)); // R4

  AST_GLB_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !glbQ |-> !irqOut); // R6

  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((stsQ & enaQ) != '0)); // R6

  AST_SOFT_RST: assert property (@(posedge clk) disable iff (!rstN)
    keyWr |=> (softRstOut && (stsQ == '0) && (enaQ == '0) && !glbQ)); // R9

  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    softRstOut |=> !softRstOut || $past(keyWr)); // R9

  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (rstAddrWr && !keyWr) |=> (!softRstOut && $stable(enaQ) && $stable(glbQ))); // R10

  AST_RVALID: assert property (@(posedge clk) disable iff (!rstN)
    regRd |=> regRvalid); // R11

endmodule

bind irqAggregator irqAggregatorChk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .STS_IDX(STS_IDX), .RST_IDX(RST_IDX), .RST_KEY(RST_KEY)
) uChk (
  .clk(clk), .rstN(rstN), .evtIn(evtIn), .regWr(regWr), .regRd(regRd),
  .regAddr(regAddr), .regWdata(regWdata), .regRvalid(regRvalid),
  .irqOut(irqOut), .softRstOut(softRstOut), .stsQ(stsQ), .enaQ(enaQ),
  .glbQ(glbQ)
);

// File: tb/sim_irqAggregator.sv
`timescale 1ns/1ps
module sim_irqAggregator;

  localparam int GLB = 7, STS = 8, ENA = 10, RST = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  evtIn = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        regRvalid;
  logic        irqOut;
  logic        softRstOut;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  irqAggregator u0 (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .regRvalid(regRvalid), .irqOut(irqOut), .softRstOut(softRstOut)
  );

  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever read data is returned.
  always @(negedge clk) begin
    if (rstN && regRvalid) begin
      if (expQ.size() == 0) begin
        checkCnt++;
        failCnt++;
        $display("FAIL R11: unexpected read data 0x%08h expected none", regRdata);
      end else begin
        checkVal(tagQ.pop_front(), regRdata, expQ.pop_front());
      end
    end
  end

  task automatic regWrite(int idx, logic [31:0] data);
    regWr    = 1'b1;
    regAddr  = 5'(idx);
    regWdata = data;
    @(negedge clk);
    regWr    = 1'b0;
  endtask

  task automatic regRead(int idx, logic [31:0] exp, string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    regRd   = 1'b1;
    regAddr = 5'(idx);
    @(negedge clk);
    regRd   = 1'b0;
    @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    tick();

    // R1 reset state
    checkVal("R1 irqOut", 32'(irqOut), 0);
    checkVal("R1 softRstOut", 32'(softRstOut), 0);
    regRead(STS, 0, "R1 status");
    regRead(ENA, 0, "R1 enable");
    regRead(GLB, 0, "R1 global");

    // R8 enable readback, R7 global bit only
    regWrite(ENA, 32'hFFFF_FFA5);
    regRead(ENA, 32'h0000_00A5, "R8 enable");
    regWrite(GLB, 32'hFFFF_FFFF);
    regRead(GLB, 32'h8000_0000, "R7 global");
    checkVal("R6 no pending", 32'(irqOut), 0);

    // R2 R3 rising edges land in their own positions
    evtIn = 8'h08; tick();
    regRead(STS, 32'h08, "R3 bit3 receive watermark");
    evtIn = 8'h88; tick();
    regRead(STS, 32'h88, "R2 bit7 set on rise");
    checkVal("R6 bit7 enabled", 32'(irqOut), 1);

    regWrite(GLB, 32'h7FFF_FFFF);
    checkVal("R6 global off", 32'(irqOut), 0);
    regWrite(GLB, 32'h8000_0000);
    regWrite(ENA, 32'h0000_0008);
    checkVal("R6 bit3 only enabled", 32'(irqOut), 1);
    regWrite(ENA, 32'h0000_0000);
    checkVal("R6 mask all", 32'(irqOut), 0);

    // R4 clear bit3 only, R2 held-high line does not re-set
    regWrite(STS, 32'h0000_0008);
    tick(); tick();
    regRead(STS, 32'h80, "R4 w1c keeps zeros");

    // R5 set wins over clear
    evtIn = 8'h89; tick();
    evtIn = 8'h88; tick();
    regRead(STS, 32'h81, "R3 bit0 arbitration");
    evtIn = 8'h89;
    regWrite(STS, 32'h0000_0001);
    regRead(STS, 32'h81, "R5 set beats clear");

    // R11 unmapped index
    regWrite(3, 32'hFFFF_FFFF);
    regRead(3, 0, "R11 unmapped read");
    regRead(RST, 0, "R11 reset reads zero");
    regRead(STS, 32'h81, "R11 unmapped write no effect");

    // R10 wrong key
    regWrite(ENA, 32'h0000_0011);
    regWrite(RST, 32'h0000_0005);
    checkVal("R10 no strobe", 32'(softRstOut), 0);
    regRead(ENA, 32'h11, "R10 enable kept");
    regRead(GLB, 32'h8000_0000, "R10 global kept");

    // R9 keyed soft reset
    regWrite(RST, 32'h0000_000A);
    checkVal("R9 strobe high", 32'(softRstOut), 1);
    tick();
    checkVal("R9 strobe one cycle", 32'(softRstOut), 0);
    regRead(STS, 0, "R9 status cleared");
    regRead(ENA, 0, "R9 enable cleared");
    regRead(GLB, 0, "R9 global cleared");
    checkVal("R9 irq low", 32'(irqOut), 0);

    tick(); tick();
    if (expQ.size() != 0) begin
      checkCnt++;
      failCnt++;
      $display("FAIL R11: actual %0d reads outstanding expected 0", expQ.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule